// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block drives the reset of a processor subsystem. It merges three reset causes into one stretched reset pulse: a digital low-supply flag produced by an external comparator, an active-low manual reset line such as a push button, and a watchdog timer that the processor keeps alive by toggling a kick input. Whenever any cause is active, reset is asserted. Once every cause has gone away, reset stays asserted for a fixed hold time and is then released. The pulse is presented both active-high and active-low.

All three external inputs are asynchronous to the clock. Each passes through a synchronizer before use. The manual reset line is filtered so that brief low glitches are discarded. The watchdog restarts on every transition of its kick input. It is held at zero for as long as reset is asserted, and a separate enable input switches it off entirely for systems that leave the kick pin undriven. Every time length is a parameter counted in clock cycles.

Top module: `reset_supervisor`

## Requirements
- R1: While `supply_low` is 1, reset is asserted. After `supply_low` rises, the outputs show reset no later than the third rising clock edge, counting two synchronizer stages and one output register.
- R2: After the last active cause clears, reset stays asserted for exactly RST_HOLD_CYC clock edges and is then released. For `supply_low` this means `rst_out` falls on the (2+RST_HOLD_CYC)-th edge after the input falls.
- R3: A low level on `man_rst_n` that persists for MR_FILT_CYC cycles after synchronization asserts reset (3+MR_FILT_CYC edges after the input falls). When the line returns high, reset is released 3+RST_HOLD_CYC edges later.
- R4: A watchdog expiry produces one reset pulse lasting RST_HOLD_CYC cycles. If no kick arrives, reset rises WD_TIMEOUT_CYC+1 edges after the watchdog starts counting.
- R5: Both a rising and a falling transition of `wd_kick` clear the watchdog count. Toggling at intervals shorter than WD_TIMEOUT_CYC never causes a reset, even when the spacing between two edges of the same direction is longer than the timeout.
- R6: While reset is asserted for any cause, the watchdog count is held at zero. Counting begins at the first edge after reset releases, no matter how long reset lasted.
- R7: When `wd_enable` is 0, the watchdog count is held at zero and never expires.
- R8: A low pulse on `man_rst_n` that lasts fewer than MR_FILT_CYC cycles has no effect on the reset outputs.
- R9: `rst_out_n` is always the complement of `rst_out`. Reset asserted means `rst_out`=1 and `rst_out_n`=0.
- R10: If a new cause appears during the hold time, the hold count restarts, and the full RST_HOLD_CYC starts over from the moment that cause clears.
- R11: While `arst_n` is low, reset is asserted. After `arst_n` is released, reset is held for exactly RST_HOLD_CYC edges before it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| supply_low | input | 1 | Asynchronous flag from the supply comparator; 1 means the supply is below threshold |
| man_rst_n | input | 1 | Asynchronous active-low manual reset request |
| wd_kick | input | 1 | Watchdog service input; every transition counts as a kick |
| wd_enable | input | 1 | Quasi-static watchdog enable; 0 stands for an undriven kick pin |
| rst_out | output | 1 | Active-high reset pulse |
| rst_out_n | output | 1 | Active-low reset pulse |

## Verification
Every internal fault in this block shows up as a shift in the edge on which the reset outputs change, so each test predicts those edges to the exact cycle. A hold counter that is off by one moves the release edge by one cycle. A watchdog that is not frozen during reset fires early after a long manual reset. A watchdog that responds to only one edge direction fires about one timeout after kicks whose same-direction spacing exceeds the timeout. A filter that is too short turns a sub-threshold glitch into a full reset pulse within a few cycles. In every case the error appears at the ports no later than one timeout period after the stimulus.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Reset causes that feed the pulse stretcher.
  typedef struct packed {
    logic supply;
    logic manual;
    logic watchdog;
  } rst_cause_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        chain_q[i] <= RST_VAL;
      end
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
  parameter int FILT_CYC = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic mr_n_s,
  output logic mr_active
);

  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] low_cnt_q, low_cnt_d;
  logic          act_q, act_d;

  always_comb begin
    low_cnt_d = low_cnt_q;
    act_d     = act_q;
    if (mr_n_s) begin
      low_cnt_d = '0;
      act_d     = 1'b0;
    end else if (!act_q) begin
      if (low_cnt_q == LAST) begin
        act_d = 1'b1;
      end else begin
        low_cnt_d = low_cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_cnt_q <= '0;
      act_q     <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_d;
      act_q     <= act_d;
    end
  end

  assign mr_active = act_q;

  // R8: activation only after the low level has lasted the full filter time
  assert_mr_persist_R8: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(act_q) |-> ($past(low_cnt_q) == LAST) && !$past(mr_n_s));

  // R3: a high level on the line drops the request on the next edge
  assert_mr_release_R3: assert property (@(posedge clk) disable iff (!arst_n)
    mr_n_s |=> !act_q);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic kick_s,
  input  logic enable,
  input  logic hold,
  output logic expired
);

  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          kick_q;
  logic          exp_q, exp_d;
  logic          kick_edge;

  assign kick_edge = kick_s ^ kick_q;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    exp_d = 1'b0;
    if (hold || !enable || kick_edge) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      kick_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      kick_q <= kick_s;
      exp_q  <= exp_d;
    end
  end

  assign expired = exp_q;

  // R6: counter frozen at zero while reset is asserted
  assert_wd_frozen_R6: assert property (@(posedge clk) disable iff (!arst_n)
    hold |=> (cnt_q == '0) && !exp_q);

  // R7: disabled watchdog never expires
  assert_wd_disabled_R7: assert property (@(posedge clk) disable iff (!arst_n)
    !enable |=> (cnt_q == '0) && !exp_q);

  // R5: either kick direction restarts the count
  assert_wd_kick_clears_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (kick_s != kick_q) |=> (cnt_q == '0) && !exp_q);

  // R4: expiry only after the full count
  assert_wd_full_count_R4: assert property (@(posedge clk) disable iff (!arst_n)
    exp_q |-> $past(cnt_q) == LAST);

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch
  import sup_pkg::*;
#(
  parameter int HOLD_CYC = 200
) (
  input  logic       clk,
  input  logic       arst_n,
  input  rst_cause_t cause,
  output logic       rst_active
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] hold_cnt_q, hold_cnt_d;
  logic          rst_q, rst_d;
  logic          any_cause;

  assign any_cause = |cause;

  always_comb begin
    hold_cnt_d = hold_cnt_q;
    rst_d      = rst_q;
    if (any_cause) begin
      hold_cnt_d = '0;
      rst_d      = 1'b1;
    end else if (rst_q) begin
      if (hold_cnt_q == LAST) begin
        hold_cnt_d = '0;
        rst_d      = 1'b0;
      end else begin
        hold_cnt_d = hold_cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_cnt_q <= '0;
      rst_q      <= 1'b1;
    end else begin
      hold_cnt_q <= hold_cnt_d;
      rst_q      <= rst_d;
    end
  end

  assign rst_active = rst_q;

  // R1: any cause forces reset on the next edge
  assert_cause_forces_reset_R1: assert property (@(posedge clk) disable iff (!arst_n)
    any_cause |=> rst_q);

  // R2: release only after the full hold with no cause present
  assert_release_after_hold_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_q) |-> ($past(hold_cnt_q) == LAST) && !$past(any_cause));

  // R10: a cause during the hold restarts the count
  assert_hold_restart_R10: assert property (@(posedge clk) disable iff (!arst_n)
    any_cause |=> hold_cnt_q == '0);

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import sup_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int MR_FILT_CYC    = 8,
  parameter int WD_TIMEOUT_CYC = 1000,
  parameter int RST_HOLD_CYC   = 200
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_low,
  input  logic man_rst_n,
  input  logic wd_kick,
  input  logic wd_enable,
  output logic rst_out,
  output logic rst_out_n
);

  localparam int NUM_IN = 3;
  // bit order {supply_low, man_rst_n, wd_kick}; idle values supply ok, button released
  localparam logic [NUM_IN-1:0] IN_IDLE = 3'b010;

  logic [NUM_IN-1:0] in_s;
  logic              supply_low_s;
  logic              man_rst_n_s;
  logic              wd_kick_s;
  logic              mr_active;
  logic              wd_expired;
  logic              rst_active;
  rst_cause_t        cause;

  sup_sync #(
    .WIDTH  (NUM_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IN_IDLE)
  ) u_sync (
    .clk   (clk),
    .arst_n(arst_n),
    .d     ({supply_low, man_rst_n, wd_kick}),
    .q     (in_s)
  );

  assign supply_low_s = in_s[2];
  assign man_rst_n_s  = in_s[1];
  assign wd_kick_s    = in_s[0];

  sup_mr_filter #(
    .FILT_CYC(MR_FILT_CYC)
  ) u_mr_filter (
    .clk      (clk),
    .arst_n   (arst_n),
    .mr_n_s   (man_rst_n_s),
    .mr_active(mr_active)
  );

  sup_watchdog #(
    .TIMEOUT_CYC(WD_TIMEOUT_CYC)
  ) u_watchdog (
    .clk    (clk),
    .arst_n (arst_n),
    .kick_s (wd_kick_s),
    .enable (wd_enable),
    .hold   (rst_active),
    .expired(wd_expired)
  );

  always_comb begin
    cause.supply   = supply_low_s;
    cause.manual   = mr_active;
    cause.watchdog = wd_expired;
  end

  sup_stretch #(
    .HOLD_CYC(RST_HOLD_CYC)
  ) u_stretch (
    .clk       (clk),
    .arst_n    (arst_n),
    .cause     (cause),
    .rst_active(rst_active)
  );

  assign rst_out   = rst_active;
  assign rst_out_n = ~rst_active;

  // R11: reset is held while the block reset is applied and on the first edge after it
  assert_poweron_asserted_R11: assert property (@(posedge clk)
    $rose(arst_n) |-> rst_out);

endmodule

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;

  localparam int HOLD = 32;
  localparam int WD   = 64;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic arst_n, supply_low, man_rst_n, wd_kick, wd_enable;
  logic rst_out, rst_out_n;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;

  typedef struct {
    int    at;
    logic  lvl;
    string req;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reset_supervisor #(
    .SYNC_STAGES   (2),
    .MR_FILT_CYC   (FILT),
    .WD_TIMEOUT_CYC(WD),
    .RST_HOLD_CYC  (HOLD)
  ) i_reset_supervisor (
    .clk       (clk),
    .arst_n    (arst_n),
    .supply_low(supply_low),
    .man_rst_n (man_rst_n),
    .wd_kick   (wd_kick),
    .wd_enable (wd_enable),
    .rst_out   (rst_out),
    .rst_out_n (rst_out_n)
  );

  // driver side: push an expected reset level for a future cycle, kept in order
  task automatic expect_at(int at, logic lvl, string req);
    exp_t e;
    int   idx;
    e.at  = at;
    e.lvl = lvl;
    e.req = req;
    idx   = sb_q.size();
    while (idx > 0 && sb_q[idx-1].at > at) idx--;
    sb_q.insert(idx, e);
  endtask

  task automatic go_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: compare scheduled items against the ports between edges
  always @(negedge clk) begin
    exp_t e;
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      e = sb_q.pop_front();
      compared++;
      if (e.at != cyc || rst_out !== e.lvl || rst_out_n !== ~e.lvl) begin
        mismatched++;
        $display("FAIL %s (R9 pair) cyc %0d: rst_out=%b rst_out_n=%b expected %b/%b",
                 e.req, cyc, rst_out, rst_out_n, e.lvl, ~e.lvl);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int c, d, e, f, k, r, t, t2;
    arst_n     = 1'b0;
    supply_low = 1'b0;
    man_rst_n  = 1'b1;
    wd_kick    = 1'b0;
    wd_enable  = 1'b0;

    // R11: asserted during block reset, then a full hold
    repeat (3) @(negedge clk);
    expect_at(cyc + 1, 1'b1, "R11");
    @(negedge clk);
    @(negedge clk);
    c = cyc;
    arst_n = 1'b1;
    expect_at(c + HOLD - 1, 1'b1, "R11");
    expect_at(c + HOLD,     1'b0, "R11");
    go_to(c + HOLD + 4);

    // R1 / R2: supply flag
    c = cyc;
    supply_low = 1'b1;
    expect_at(c + 2, 1'b0, "R1");
    expect_at(c + 3, 1'b1, "R1");
    go_to(c + 20);
    d = cyc;
    supply_low = 1'b0;
    expect_at(d + 1 + HOLD, 1'b1, "R2");
    expect_at(d + 2 + HOLD, 1'b0, "R2");
    go_to(d + HOLD + 6);

    // R10: new cause inside the hold window
    c = cyc;
    supply_low = 1'b1;
    go_to(c + 10);
    d = cyc;
    supply_low = 1'b0;
    go_to(d + 10);
    e = cyc;
    expect_at(e + 2, 1'b1, "R10");
    supply_low = 1'b1;
    go_to(e + 5);
    f = cyc;
    supply_low = 1'b0;
    expect_at(d + 2 + HOLD, 1'b1, "R10");
    expect_at(f + 1 + HOLD, 1'b1, "R10");
    expect_at(f + 2 + HOLD, 1'b0, "R10");
    go_to(f + HOLD + 6);

    // R3: manual reset
    c = cyc;
    man_rst_n = 1'b0;
    expect_at(c + 2 + FILT, 1'b0, "R3");
    expect_at(c + 3 + FILT, 1'b1, "R3");
    go_to(c + 30);
    d = cyc;
    man_rst_n = 1'b1;
    expect_at(d + 2 + HOLD, 1'b1, "R3");
    expect_at(d + 3 + HOLD, 1'b0, "R3");
    go_to(d + HOLD + 6);

    // R8: glitches shorter than the filter time
    for (int g = 0; g < 5; g++) begin
      c = cyc;
      man_rst_n = 1'b0;
      go_to(c + FILT - 1);
      man_rst_n = 1'b1;
      expect_at(c + FILT + 4, 1'b0, "R8");
      go_to(c + FILT + 6);
    end

    // R6 / R4: long manual reset with the watchdog enabled, then expiry
    c = cyc;
    man_rst_n = 1'b0;
    wd_enable = 1'b1;
    expect_at(c + 100, 1'b1, "R6");
    go_to(c + 150);
    d = cyc;
    man_rst_n = 1'b1;
    r = d + 3 + HOLD;
    expect_at(r - 1, 1'b1, "R3");
    expect_at(r,     1'b0, "R3");
    expect_at(r + WD,     1'b0, "R6");
    expect_at(r + WD + 1, 1'b1, "R4");
    t = r + WD + 1;
    expect_at(t + HOLD - 1, 1'b1, "R4");
    expect_at(t + HOLD,     1'b0, "R4");
    go_to(t + HOLD + 5);

    // R5: toggling every 40 cycles; same-direction spacing 80 exceeds the timeout
    k = cyc;
    for (int n = 0; n < 8; n++) begin
      k = cyc;
      wd_kick = ~wd_kick;
      expect_at(k + 39, 1'b0, "R5");
      go_to(k + 40);
    end
    expect_at(k + 3 + WD, 1'b0, "R5");
    expect_at(k + 4 + WD, 1'b1, "R4");
    t2 = k + 4 + WD;

    // R7: disable during the resulting reset; no further expiry
    go_to(t2 + 5);
    wd_enable = 1'b0;
    expect_at(t2 + HOLD,           1'b0, "R4");
    expect_at(t2 + HOLD + WD + 5,  1'b0, "R7");
    expect_at(t2 + HOLD + 2*WD,    1'b0, "R7");
    expect_at(t2 + HOLD + 3*WD,    1'b0, "R7");
    go_to(t2 + HOLD + 3*WD + 3);

    if (sb_q.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule